// File: doc/BRIEF.md
# Four-Channel Alarm Interrupt Unit

This block provides four independent one-shot alarms that watch the low 32 bits of a free-running timebase supplied from outside. Software arms an alarm simply by writing its 32-bit target; once the timebase low word equals that target at a clock edge, the alarm fires. Firing latches a per-channel raw interrupt bit and drops the channel's armed flag.

Each channel's interrupt line is built from three register bits: the latched raw bit, a software force bit and an enable bit. The line is high when the enable bit is set and either the raw bit or the force bit is set. All state is reached through a simple 32-bit register bus with a single-cycle write strobe and combinational read data. Byte offsets are word aligned. The target registers occupy 0x00 to 0x0C, and the armed, raw, enable, force and status registers follow at 0x10, 0x14, 0x18, 0x1C and 0x20.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset every register reads 0 and every bit of irq_o is low.
- R2: A write to byte offset 4*i (i = 0..3) stores the 32-bit target of channel i, which reads back at the same offset. The same write sets bit i of the armed register (offset 0x10, bits 3:0), visible after that edge.
- R3: An armed channel whose target equals time_lo_i at a clock edge fires. After that edge its armed bit is 0 and its raw bit (offset 0x14, bit i) is 1. An unarmed channel, or a channel whose target differs from time_lo_i, never sets its raw bit.
- R4: Writing 1 to armed bit i disarms channel i without setting its raw bit. Writing 0 to a bit of the armed register leaves that bit unchanged.
- R5: Writing 1 to raw bit i clears it, and writing 0 leaves it unchanged. If channel i fires at the same edge as the clear, the raw bit ends at 1.
- R6: The enable register (offset 0x18) and the force register (offset 0x1C) each hold bits 3:0 and read back the last value written.
- R7: The status register (offset 0x20) reads (raw | force) & enable in bits 3:0. Writes to it are ignored.
- R8: irq_o[i] equals status bit i and follows register changes with no extra cycle of delay.
- R9: Writing a new target to an armed channel replaces the target and keeps the channel armed. The old target no longer fires, and the new one does.
- R10: A target write at the same edge that the timebase matches the channel's old target suppresses firing at that edge, and the channel stays armed. Word offsets 0x24 to 0x3C read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_lo_i | input | 32 | Low word of the external timebase |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable, qualified by bus_sel_i |
| bus_addr_i | input | 6 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| irq_o | output | 4 | Per-channel interrupt lines |

## Verification
Register writes, arming, disarming and firing all take effect on the clock edge that samples them, so the bench drives each stimulus on a falling edge and reads the result on the following falling edge, one edge later. Read data and irq_o are combinational from state, so the bench samples them a few nanoseconds after changing the address and does not wait for a clock edge. The timebase is stepped one value per cycle across each target while a model tracks the expected armed and raw masks. Every same-edge conflict is set up by changing the timebase and the bus in the same falling-edge slot.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/1ps
package alarm_irq_pkg;
  typedef enum logic [2:0] {
    K_TARGET, K_ARMED, K_RAW, K_ENABLE, K_FORCE, K_STATUS, K_NONE
  } reg_kind_e;

  // word layout: targets first, then control words in fixed order
  function automatic reg_kind_e decode_kind(input int unsigned word, input int unsigned n);
    if (word < n)           return K_TARGET;
    else if (word == n)     return K_ARMED;
    else if (word == n + 1) return K_RAW;
    else if (word == n + 2) return K_ENABLE;
    else if (word == n + 3) return K_FORCE;
    else if (word == n + 4) return K_STATUS;
    else                    return K_NONE;
  endfunction
endpackage

// File: rtl/alarm_reg_decode.sv
`timescale 1ns/1ps
module alarm_reg_decode
  import alarm_irq_pkg::*;
#(
  parameter int NUM_ALARMS = 4,
  parameter int ADDR_W     = 6,
  localparam int CH_W      = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1,
  localparam int WORD_W    = ADDR_W - 2
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              wr_o
);
  logic [WORD_W-1:0] word;

  always_comb begin
    word   = addr_i[ADDR_W-1:2];
    kind_o = decode_kind(32'(word), NUM_ALARMS);
    ch_o   = word[CH_W-1:0];
    wr_o   = sel_i & we_i;
  end
endmodule

// File: rtl/alarm_channel.sv
`timescale 1ns/1ps
module alarm_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] time_i,
  input  logic              tgt_wr_i,
  input  logic              disarm_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] target_o,
  output logic              armed_o,
  output logic              fire_o
);
  logic [DATA_W-1:0] target_q;
  logic              armed_q, armed_d;

  // a bus write to this channel takes precedence over a match
  always_comb begin
    fire_o  = armed_q & (time_i == target_q) & ~tgt_wr_i & ~disarm_i;
    armed_d = armed_q;
    if (tgt_wr_i)               armed_d = 1'b1;
    else if (disarm_i | fire_o) armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (tgt_wr_i) target_q <= wdata_i;
      armed_q <= armed_d;
    end
  end

  assign target_o = target_q;
  assign armed_o  = armed_q;

  assert_arm_on_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_wr_i |=> armed_o && target_o == $past(wdata_i));
  assert_fire_disarms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_o);
  assert_disarm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i && !tgt_wr_i |=> !armed_o);
  assert_keep_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_wr_i |=> $stable(target_o));
endmodule

// File: rtl/alarm_irq_bank.sv
`timescale 1ns/1ps
module alarm_irq_bank #(
  parameter int NUM_ALARMS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_ALARMS-1:0] fire_i,
  input  logic                  raw_wr_i,
  input  logic                  en_wr_i,
  input  logic                  frc_wr_i,
  input  logic [NUM_ALARMS-1:0] wdata_i,
  output logic [NUM_ALARMS-1:0] raw_o,
  output logic [NUM_ALARMS-1:0] en_o,
  output logic [NUM_ALARMS-1:0] frc_o,
  output logic [NUM_ALARMS-1:0] status_o
);
  logic [NUM_ALARMS-1:0] raw_q, en_q, frc_q, clr;

  assign clr = raw_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | fire_i; // set wins over clear
      if (en_wr_i)  en_q  <= wdata_i;
      if (frc_wr_i) frc_q <= wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign frc_o    = frc_q;
  assign status_o = (raw_q | frc_q) & en_q;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
    assert_fire_sets_raw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[i] |=> raw_o[i]);
    assert_raw_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raw_wr_i && wdata_i[i] && !fire_i[i] |=> !raw_o[i]);
    assert_raw_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raw_o[i] && !(raw_wr_i && wdata_i[i]) |=> raw_o[i]);
    assert_status_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[i] |-> en_o[i] && (raw_o[i] || frc_o[i]));
  end
endmodule

// File: rtl/alarm_irq_unit.sv
`timescale 1ns/1ps
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int NUM_ALARMS = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  localparam int CH_W      = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_W-1:0]     time_lo_i,
  input  logic                  bus_sel_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic [NUM_ALARMS-1:0] irq_o
);
  reg_kind_e             kind;
  logic [CH_W-1:0]       ch;
  logic                  wr;
  logic [DATA_W-1:0]     target [NUM_ALARMS];
  logic [NUM_ALARMS-1:0] armed, fire, raw, en, frc, status;

  alarm_reg_decode #(.NUM_ALARMS(NUM_ALARMS), .ADDR_W(ADDR_W)) u_dec (
    .sel_i (bus_sel_i),
    .we_i  (bus_we_i),
    .addr_i(bus_addr_i),
    .kind_o(kind),
    .ch_o  (ch),
    .wr_o  (wr)
  );

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_ch
    logic tgt_wr, disarm;
    assign tgt_wr = wr && kind == K_TARGET && ch == CH_W'(i);
    assign disarm = wr && kind == K_ARMED && bus_wdata_i[i];

    alarm_channel #(.DATA_W(DATA_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .time_i  (time_lo_i),
      .tgt_wr_i(tgt_wr),
      .disarm_i(disarm),
      .wdata_i (bus_wdata_i),
      .target_o(target[i]),
      .armed_o (armed[i]),
      .fire_o  (fire[i])
    );
  end

  alarm_irq_bank #(.NUM_ALARMS(NUM_ALARMS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .raw_wr_i(wr && kind == K_RAW),
    .en_wr_i (wr && kind == K_ENABLE),
    .frc_wr_i(wr && kind == K_FORCE),
    .wdata_i (bus_wdata_i[NUM_ALARMS-1:0]),
    .raw_o   (raw),
    .en_o    (en),
    .frc_o   (frc),
    .status_o(status)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (kind)
      K_TARGET: bus_rdata_o = target[ch];
      K_ARMED:  bus_rdata_o[NUM_ALARMS-1:0] = armed;
      K_RAW:    bus_rdata_o[NUM_ALARMS-1:0] = raw;
      K_ENABLE: bus_rdata_o[NUM_ALARMS-1:0] = en;
      K_FORCE:  bus_rdata_o[NUM_ALARMS-1:0] = frc;
      K_STATUS: bus_rdata_o[NUM_ALARMS-1:0] = status;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = status;

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~en) == '0);
  assert_unarmed_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire & ~armed) == '0);
endmodule

// File: tb/alarm_irq_unit_tb_top.sv
`timescale 1ns/1ps
module alarm_irq_unit_tb_top;
  localparam int N = 4;
  localparam logic [5:0] A_ARM = 6'h10, A_RAW = 6'h14, A_EN = 6'h18, A_FRC = 6'h1C, A_STS = 6'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tm = 32'hFFFF_0000;
  logic        sel = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] irq;
  int checks = 0, errors = 0;
  logic [31:0] tgt [N];
  logic [3:0]  arm_m, raw_m;
  logic [31:0] rd;

  always #10 clk = ~clk; // 50 MHz

  alarm_irq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .time_lo_i(tm), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rdreg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #2;
    d = rdata;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int w = 0; w < 9; w++) begin
      rdreg(6'(4 * w), rd);
      chk("R1 reset reg", rd, 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 32'h0);

    // R2: arm each channel by writing target
    arm_m = '0;
    for (int c = 0; c < N; c++) begin
      tgt[c] = 32'h100 + 32'(c * 8);
      wr(6'(4 * c), tgt[c]);
      arm_m[c] = 1'b1;
      rdreg(6'(4 * c), rd);
      chk("R2 target readback", rd, tgt[c]);
      rdreg(A_ARM, rd);
      chk("R2 armed mask", rd, 32'(arm_m));
    end

    // R3/R8: sweep timebase across all targets, enable off
    raw_m = '0;
    for (int t = 32'hFE; t < 32'h130; t++) begin
      @(negedge clk); tm = 32'(t);
      @(posedge clk);
      for (int c = 0; c < N; c++)
        if (arm_m[c] && tm == tgt[c]) begin arm_m[c] = 1'b0; raw_m[c] = 1'b1; end
      #3; addr = A_ARM; #1; chk("R3 armed during sweep", rdata, 32'(arm_m));
      addr = A_RAW; #1; chk("R3 raw during sweep", rdata, 32'(raw_m));
      chk("R8 irq masked", 32'(irq), 32'h0);
    end
    @(negedge clk); tm = 32'hFFFF_0000;

    // R5: raw write-one-to-clear
    wr(A_RAW, 32'h0);  rdreg(A_RAW, rd); chk("R5 write 0 keeps raw", rd, 32'hF);
    wr(A_RAW, 32'h5);  rdreg(A_RAW, rd); chk("R5 partial clear", rd, 32'hA);
    wr(A_RAW, 32'hA);  rdreg(A_RAW, rd); chk("R5 full clear", rd, 32'h0);

    // R6: enable/force readback sweep
    for (int v = 0; v < 16; v++) begin
      wr(A_EN, 32'(v));  rdreg(A_EN, rd);  chk("R6 enable readback", rd, 32'(v));
      wr(A_FRC, 32'(15 - v)); rdreg(A_FRC, rd); chk("R6 force readback", rd, 32'(15 - v));
    end
    wr(A_EN, 32'h0); wr(A_FRC, 32'h0);

    // set raw = 0x6 by firing channels 1 and 2
    wr(6'h04, 32'h180); wr(6'h08, 32'h181);
    @(negedge clk); tm = 32'h180; @(negedge clk); tm = 32'h181; @(negedge clk); tm = 32'hFFFF_0000;
    rdreg(A_RAW, rd); chk("R3 refire raw", rd, 32'h6);

    // R7/R8: exhaustive enable x force with raw = 0x6
    for (int e = 0; e < 16; e++)
      for (int f = 0; f < 16; f++) begin
        wr(A_EN, 32'(e)); wr(A_FRC, 32'(f));
        rdreg(A_STS, rd);
        chk("R7 status", rd, 32'((4'h6 | 4'(f)) & 4'(e)));
        chk("R8 irq", 32'(irq), 32'((4'h6 | 4'(f)) & 4'(e)));
      end
    wr(A_STS, 32'h0); rdreg(A_STS, rd); chk("R7 status write ignored", rd, 32'hF);
    wr(A_EN, 32'h0); wr(A_FRC, 32'h0); wr(A_RAW, 32'hF);

    // R4: disarm
    wr(6'h00, 32'h200);
    wr(A_ARM, 32'h0); rdreg(A_ARM, rd); chk("R4 write 0 keeps armed", rd, 32'h1);
    wr(A_ARM, 32'h1); rdreg(A_ARM, rd); chk("R4 disarm", rd, 32'h0);
    @(negedge clk); tm = 32'h200; @(negedge clk); tm = 32'hFFFF_0000;
    rdreg(A_RAW, rd); chk("R4 disarmed no fire", rd, 32'h0);

    // R9: retarget while armed
    wr(6'h0C, 32'h300); wr(6'h0C, 32'h310);
    @(negedge clk); tm = 32'h300; @(negedge clk); tm = 32'hFFFF_0000;
    rdreg(A_RAW, rd); chk("R9 old target silent", rd, 32'h0);
    rdreg(A_ARM, rd); chk("R9 still armed", rd, 32'h8);
    rdreg(6'h0C, rd); chk("R9 new target", rd, 32'h310);
    @(negedge clk); tm = 32'h310; @(negedge clk); tm = 32'hFFFF_0000;
    rdreg(A_RAW, rd); chk("R9 new target fires", rd, 32'h8);
    wr(A_RAW, 32'hF);

    // R10: target write at match edge suppresses fire
    wr(6'h08, 32'h400);
    @(negedge clk); tm = 32'h400; sel = 1'b1; we = 1'b1; addr = 6'h08; wdata = 32'h400;
    @(posedge clk); #2; sel = 1'b0; we = 1'b0; addr = A_RAW; #1;
    chk("R10 write wins raw", rdata, 32'h0);
    addr = A_ARM; #1; chk("R10 write wins armed", rdata, 32'h4);
    @(posedge clk); #2; addr = A_RAW; #1;
    chk("R10 fires next edge", rdata, 32'h4);
    @(negedge clk); tm = 32'hFFFF_0000;

    // R5: fire beats clear at same edge
    wr(6'h08, 32'h500);
    @(negedge clk); tm = 32'h500; sel = 1'b1; we = 1'b1; addr = A_RAW; wdata = 32'h4;
    @(posedge clk); #2; sel = 1'b0; we = 1'b0; #1;
    chk("R5 set wins over clear", rdata, 32'h4);
    @(negedge clk); tm = 32'hFFFF_0000;

    // R10: unmapped words read zero
    for (int w = 9; w < 16; w++) begin
      rdreg(6'(4 * w), rd);
      chk("R10 unmapped zero", rd, 32'h0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule